// File: doc/BRIEF.md
# Protected-Mode Segment Access Checker

This block decides whether one memory access may proceed against the cached descriptor of its segment. Each request supplies the protection-enable state, the segment's 8-bit access-rights byte, its limit, the offset within the segment, the access width and the kind of operation. One cycle later the block gives one of two results: a single-cycle grant pulse, or a single-cycle general-protection fault pulse together with a 2-bit code that says which check failed.

With protection disabled, every request is granted. With protection enabled, three checks apply in a fixed priority order. First the present bit, then the segment bound, and last the rights needed by the operation. The bound test adds the offset and the access size at one bit wider than the offset, so an access that runs past the top of the address space cannot wrap round and look legal. Loading descriptors, delivering the fault and marking a segment as accessed all belong to the surrounding pipeline.

Top module: `seg_access_check`

## Requirements
- R1: When `pm_en` is 0, a request is always granted, whatever the rights, limit, offset, size and operation.
- R2: With `pm_en` 1, a request faults with cause 1 when bit 7 (present) of `rights` is 0.
- R3: With `pm_en` 1, a request faults with cause 2 when offset plus size is greater than `limit`. The size is 1 when `size_word` is 0 and 2 when `size_word` is 1. An access whose end equals the limit is in bounds.
- R4: A read (`op` = 1) passes the rights check when bit 3 of `rights` is 0, or when bits 3 and 1 are both 1. Otherwise it faults with cause 3.
- R5: A write (`op` = 2) passes the rights check only when bit 3 of `rights` is 0 and bit 1 is 1. Otherwise it faults with cause 3.
- R6: An execute request (`op` = 3) and the unused code `op` = 0 get no rights check.
- R7: When several checks fail, the cause is the first failing check in the order present (1), bound (2), rights (3). `fault_cause` is 0 whenever `fault` is 0.
- R8: The bound sum is formed one bit wider than the offset. An offset of all ones with a limit of all ones therefore faults on a byte access.
- R9: Each cycle with `req` high gives exactly one of `grant` or `fault` one cycle later, as a single-cycle pulse. A cycle without `req` gives neither. Back-to-back requests are each answered.
- R10: While `rst_n` is low, `grant`, `fault` and `fault_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe |
| pm_en | input | 1 | Protection enabled |
| rights | input | 8 | Segment access-rights byte |
| limit | input | OFS_W | Segment limit |
| offset | input | OFS_W | Access offset within the segment |
| size_word | input | 1 | 0 = byte access, 1 = word access |
| op | input | 2 | 1 = read, 2 = write, 3 = execute |
| grant | output | 1 | Access allowed, one cycle after the request |
| fault | output | 1 | Protection fault, one cycle after the request |
| fault_cause | output | 2 | 1 = absent, 2 = out of bounds, 3 = rights; 0 when no fault |

## Verification
The block holds no state across requests except its output register. A wrong decision therefore shows up at the ports in the cycle straight after the request that caused it: a grant in place of a fault, or a wrong cause code. The stimulus is aimed at the edges of each decision: an access that ends exactly on the limit and one that ends one past it, the all-ones offset where a sum of the offset's width would wrap, and each combination of rights bits 3 and 1 for reads and writes. Requests that fail more than one check show whether the priority order has been inverted. A stuck or stretched output pulse is caught on the idle cycle that follows a run of back-to-back requests.

// File: rtl/seg_access_check.sv
module seg_access_check #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             pm_en,
  input  logic [7:0]       rights,
  input  logic [OFS_W-1:0] limit,
  input  logic [OFS_W-1:0] offset,
  input  logic             size_word,
  input  logic [1:0]       op,
  output logic             grant,
  output logic             fault,
  output logic [1:0]       fault_cause
);
  localparam int SUM_W = OFS_W + 1;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_WR = 2'd2;
  localparam logic [1:0] C_OK = 2'd0, C_ABSENT = 2'd1, C_BOUND = 2'd2, C_RIGHTS = 2'd3;

  logic [SUM_W-1:0] end_pos;
  logic             present, over, readable, writable, rights_ok;
  logic [1:0]       cause_n;

  assign end_pos   = {1'b0, offset} + SUM_W'(size_word ? 2 : 1);
  assign over      = end_pos > {1'b0, limit};
  assign present   = rights[7];
  assign readable  = ~rights[3] | rights[1];
  assign writable  = ~rights[3] & rights[1];
  assign rights_ok = (op == OP_RD) ? readable :
                     (op == OP_WR) ? writable : 1'b1;

  always_comb begin
    if (!pm_en)          cause_n = C_OK;
    else if (!present)   cause_n = C_ABSENT;
    else if (over)       cause_n = C_BOUND;
    else if (!rights_ok) cause_n = C_RIGHTS;
    else                 cause_n = C_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant       <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= C_OK;
    end else begin
      grant       <= req && (cause_n == C_OK);
      fault       <= req && (cause_n != C_OK);
      fault_cause <= req ? cause_n : C_OK;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (grant ^ fault)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !(grant || fault)); // R9
  AST_REAL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !pm_en) |=> grant); // R1
  AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req && pm_en && !rights[7]) |=> (fault && fault_cause == 2'd1)); // R2
  AST_NO_WRITE_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && pm_en && op == 2'd2 && rights[3]) |=> !grant); // R5
  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (fault_cause == 2'd0)); // R7
endmodule

// File: tb/seg_access_check_bench.sv
`timescale 1ns/1ps
module seg_access_check_bench;
  logic clk = 0, rst_n = 0, req = 0, pm_en = 0, size_word = 0;
  logic [7:0]  rights = 0;
  logic [15:0] limit = 0, offset = 0;
  logic [1:0]  op = 0;
  logic grant, fault;
  logic [1:0] fault_cause;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  seg_access_check u_seg_access_check (
    .clk(clk), .rst_n(rst_n), .req(req), .pm_en(pm_en), .rights(rights),
    .limit(limit), .offset(offset), .size_word(size_word), .op(op),
    .grant(grant), .fault(fault), .fault_cause(fault_cause));

  // {pm, rights, limit, offset, word, op, exp_grant, exp_cause}
  localparam int N = 18;
  localparam logic [46:0] VEC [N] = '{
    {1'b0, 8'h00, 16'h0000, 16'hFFFF, 1'b1, 2'd2, 1'b1, 2'd0},
    {1'b1, 8'h12, 16'hFFFF, 16'h0000, 1'b0, 2'd1, 1'b0, 2'd1},
    {1'b1, 8'h92, 16'h0010, 16'h000F, 1'b1, 2'd1, 1'b0, 2'd2},
    {1'b1, 8'h92, 16'h0010, 16'h000E, 1'b1, 2'd1, 1'b1, 2'd0},
    {1'b1, 8'h92, 16'h0010, 16'h000F, 1'b0, 2'd1, 1'b1, 2'd0},
    {1'b1, 8'h92, 16'hFFFF, 16'hFFFF, 1'b0, 2'd1, 1'b0, 2'd2},
    {1'b1, 8'h92, 16'hFFFF, 16'hFFFE, 1'b0, 2'd1, 1'b1, 2'd0},
    {1'b1, 8'h92, 16'h0100, 16'h0020, 1'b1, 2'd2, 1'b1, 2'd0},
    {1'b1, 8'h9A, 16'h0100, 16'h0020, 1'b1, 2'd2, 1'b0, 2'd3},
    {1'b1, 8'h9A, 16'h0100, 16'h0020, 1'b1, 2'd1, 1'b1, 2'd0},
    {1'b1, 8'h98, 16'h0100, 16'h0020, 1'b1, 2'd1, 1'b0, 2'd3},
    {1'b1, 8'h98, 16'h0100, 16'h0020, 1'b1, 2'd2, 1'b0, 2'd3},
    {1'b1, 8'h90, 16'h0100, 16'h0020, 1'b0, 2'd2, 1'b0, 2'd3},
    {1'b1, 8'h90, 16'h0100, 16'h0020, 1'b0, 2'd1, 1'b1, 2'd0},
    {1'b1, 8'h98, 16'h0100, 16'h0020, 1'b0, 2'd3, 1'b1, 2'd0},
    {1'b1, 8'h98, 16'h0100, 16'h0020, 1'b0, 2'd0, 1'b1, 2'd0},
    {1'b1, 8'h18, 16'h0001, 16'h0040, 1'b1, 2'd2, 1'b0, 2'd1},
    {1'b1, 8'h98, 16'h0001, 16'h0040, 1'b1, 2'd2, 1'b0, 2'd2}
  };
  localparam string TAG [N] = '{
    "R1 real mode", "R2 absent", "R3 word one past limit", "R3 word ends on limit",
    "R3 byte ends on limit", "R8 all-ones offset", "R8 below top",
    "R5 writable data", "R5 write to readable code", "R4 read readable code",
    "R4 read exec-only", "R5 write exec-only", "R5 write read-only data",
    "R4 read read-only data", "R6 execute", "R6 op zero",
    "R7 absent beats bound", "R7 bound beats rights"
  };

  task automatic check(string tag, logic g, logic f, logic [1:0] c,
                       logic eg, logic ef, logic [1:0] ec);
    checks++;
    if (g !== eg || f !== ef || c !== ec) begin
      errors++;
      $display("FAIL %s: grant=%0b fault=%0b cause=%0d expected grant=%0b fault=%0b cause=%0d",
               tag, g, f, c, eg, ef, ec);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req = 1; pm_en = 1;
    repeat (3) @(negedge clk);
    check("R10 reset", grant, fault, fault_cause, 0, 0, 0);
    rst_n = 1; req = 0;
    @(negedge clk);
    check("R9 idle after reset", grant, fault, fault_cause, 0, 0, 0);
    for (int i = 0; i < N; i++) begin
      {pm_en, rights, limit, offset, size_word, op} = VEC[i][46:3];
      req = 1;
      @(negedge clk);
      check(TAG[i], grant, fault, fault_cause, VEC[i][2], !VEC[i][2], VEC[i][1:0]);
    end
    req = 0;
    @(negedge clk);
    check("R9 pulse ends", grant, fault, fault_cause, 0, 0, 0);
    pm_en = 0; rights = 8'h00; limit = 0; offset = 16'hFFFF; size_word = 1; op = 2'd1;
    @(negedge clk);
    check("R9 no request no result", grant, fault, fault_cause, 0, 0, 0);
    pm_en = 1; rights = 8'h9A; limit = 16'h0003; offset = 16'h0002; size_word = 0; op = 2'd2;
    req = 1;
    @(negedge clk);
    check("R5 rights fault in bounds", grant, fault, fault_cause, 0, 1, 3);
    req = 0;
    @(negedge clk);
    check("R7 cause clears", grant, fault, fault_cause, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule